// File: doc/BRIEF.md
# Emulation Debug Slave Controller

One of these controllers sits on every FPGA of a multi-FPGA processor emulator. A master on the host side reaches it over a shared debug bus. The master uses it to freeze the emulated processor, to release a chosen number of core cycles, to read the controller's registers, and to read and write a small local memory. The core clock and the DMA clock are both divided down from the fabric clock. The controller therefore samples them as levels on its own clock `clk` and reacts to their rising edges. `core_en` is the enable that gates every pipeline stage of the target.

The controller is a four-state machine:

- **RUN**: the target runs freely.
- **HALT**: the target is frozen and commands are accepted.
- **STEP**: a counted release of core cycles is in progress.
- **MEM**: a memory access is waiting for the next DMA-clock edge.

The transitions are:

- **freeze**: RUN to HALT when `dbg_mode` rises.
- **release**: any state to RUN when `dbg_mode` is low.
- **step_go**: HALT to STEP on a step command with a non-zero count.
- **step_done**: STEP to HALT on the core edge that uses up the count.
- **mem_go**: HALT to MEM on a memory read or write.
- **mem_done**: MEM to HALT on the next DMA rising edge.

The identifiers are parameters, so every FPGA is strapped with its own chip number. The master addresses one controller by that chip number plus a debug-module number.

Top module: `emu_dbg_slave`

## Requirements
- R1: After reset, `core_en` is 0 and `dbg_rdata` is 0. The machine starts in HALT.
- R2: When `dbg_mode` is low in a cycle, `core_en` is 1 in the next cycle (release). When `dbg_mode` rises, `core_en` is 0 in the next cycle (freeze).
- R3: A request is taken when `dbg_req` is 1 at a `clk` rising edge. The address bus is split into fields: bits [15:12] are the chip number, bits [11:8] the module number, bits [7:6] the operation, and bits [5:0] the address. The operation codes are 0 = none, 1 = read, 2 = write and 3 = step. A request with operation 0 changes nothing.
- R4: A request whose chip number differs from `CHIP_ID`, or whose module number differs from `MOD_ID`, has no effect, and `dbg_rdata` is 0 in the next cycle.
- R5: A step command in HALT with count N = `dbg_wdata[7:0]` > 0 holds `core_en` at 1 for exactly N rising edges of `core_clk_in`. After that, `core_en` returns to 0.
- R6: A step command with count 0 releases no core cycle. The machine stays in HALT.
- R7: Register reads return these values:
  - Address 0 is status: bit 0 frozen (HALT or MEM), bit 1 step pending, bit 2 memory busy.
  - Address 1 is the remaining step count.
  - Address 2 is {`CHIP_ID`, `MOD_ID`} in bits [7:0].
- R8: Addresses 32 to 47 select memory word k = address - 32. A read or write enters MEM. The access completes on the first `dma_clk_in` rising edge after that. A write stores `dbg_wdata`. A read places the word on `dbg_rdata` in the cycle after that edge.
- R9: Register reads are accepted in HALT, STEP and MEM. Step commands and memory accesses are accepted only in HALT. In RUN, every matched request is ignored and `dbg_rdata` is left unchanged.
- R10: A register read shows its value on `dbg_rdata` in the cycle after the request edge. The value stays there until the next read result or the next identifier mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_mode | input | 1 | High: target frozen, commands accepted |
| dbg_req | input | 1 | Request strobe, one cycle |
| dbg_addr | input | 16 | Chip, module, operation and address fields |
| dbg_wdata | input | 16 | Write data, or step count in bits [7:0] |
| core_clk_in | input | 1 | Divided core clock, sampled as a level |
| dma_clk_in | input | 1 | Divided DMA clock, sampled as a level |
| dbg_rdata | output | 16 | Read result returned to the master |
| core_en | output | 1 | Pipeline enable for the target |

## Verification
The bound checker watches every cycle for the following:

- The release and freeze response of `core_en` to `dbg_mode`.
- The zeroing of read data after a foreign identifier.
- A decrement of the remaining count by one on each core edge during a step.
- A STEP state never holding a zero count.
- A zero-count step never opening the enable.

Only the bench scenarios can show the rest. These are the exact number of enabled core edges for a sweep of step counts, the write and read-back of every memory word through DMA edges, and the commands that are ignored while stepping, while busy or in RUN. The status values seen during a step and during a pending access also rest on the scenarios.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STEP = 2'd2,
        ST_MEM  = 2'd3
    } dbg_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_STEP  = 2'd3
    } dbg_op_e;

    localparam int OP_W = 2;

endpackage

// File: rtl/dbg_rise_det.sv
module dbg_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/dbg_field_dec.sv
module dbg_field_dec #(
    parameter int CHIP_W = 4,
    parameter int MOD_W  = 4,
    parameter int REG_AW = 6,
    parameter logic [CHIP_W-1:0] CHIP_ID = '0,
    parameter logic [MOD_W-1:0]  MOD_ID  = '0,
    localparam int AW = CHIP_W + MOD_W + dbg_pkg::OP_W + REG_AW
) (
    input  logic [AW-1:0]      bus,
    output logic               id_ok,
    output logic [1:0]         op,
    output logic [REG_AW-1:0]  reg_addr,
    output logic               is_mem
);
    logic [CHIP_W-1:0] chip_f;
    logic [MOD_W-1:0]  mod_f;

    assign chip_f   = bus[AW-1 -: CHIP_W];
    assign mod_f    = bus[AW-CHIP_W-1 -: MOD_W];
    assign op       = bus[REG_AW +: dbg_pkg::OP_W];
    assign reg_addr = bus[REG_AW-1:0];
    assign is_mem   = bus[REG_AW-1];
    assign id_ok    = (chip_f == CHIP_ID) && (mod_f == MOD_ID);
endmodule

// File: rtl/dbg_step_ctr.sv
module dbg_step_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] remain,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        remain <= '0;
        else if (load)            remain <= load_val;
        else if (dec && remain != '0) remain <= remain - CW'(1);
    end

    assign last = (remain == CW'(1));
endmodule

// File: rtl/dbg_dma_mem.sv
module dbg_dma_mem #(
    parameter int DW     = 16,
    parameter int MEM_AW = 4,
    localparam int DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[idx] <= wdata;
    end

    assign rdata = words[idx];
endmodule

// File: rtl/emu_dbg_slave.sv
module emu_dbg_slave #(
    parameter int CHIP_W = 4,
    parameter int MOD_W  = 4,
    parameter int REG_AW = 6,
    parameter int DW     = 16,
    parameter int CW     = 8,
    parameter int MEM_AW = 4,
    parameter logic [CHIP_W-1:0] CHIP_ID = 4'h5,
    parameter logic [MOD_W-1:0]  MOD_ID  = 4'h7,
    localparam int AW = CHIP_W + MOD_W + dbg_pkg::OP_W + REG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_mode,
    input  logic          dbg_req,
    input  logic [AW-1:0] dbg_addr,
    input  logic [DW-1:0] dbg_wdata,
    input  logic          core_clk_in,
    input  logic          dma_clk_in,
    output logic [DW-1:0] dbg_rdata,
    output logic          core_en
);
    import dbg_pkg::*;

    localparam logic [REG_AW-1:0] A_STATUS = REG_AW'(0);
    localparam logic [REG_AW-1:0] A_REMAIN = REG_AW'(1);
    localparam logic [REG_AW-1:0] A_IDENT  = REG_AW'(2);

    dbg_state_e state, state_nx;

    // clock-level edge detection, one detector per sampled clock
    logic [1:0] lvl, rise;
    logic core_rise, dma_rise;
    assign lvl = {dma_clk_in, core_clk_in};
    for (genvar g = 0; g < 2; g++) begin : g_edge
        dbg_rise_det u_det (.clk(clk), .rst_n(rst_n), .level(lvl[g]), .rise(rise[g]));
    end
    assign core_rise = rise[0];
    assign dma_rise  = rise[1];

    // field decode
    logic              id_ok, is_mem;
    logic [1:0]        op;
    logic [REG_AW-1:0] reg_addr;
    dbg_field_dec #(.CHIP_W(CHIP_W), .MOD_W(MOD_W), .REG_AW(REG_AW),
                    .CHIP_ID(CHIP_ID), .MOD_ID(MOD_ID)) u_dec (
        .bus(dbg_addr), .id_ok(id_ok), .op(op), .reg_addr(reg_addr), .is_mem(is_mem)
    );

    logic req_ok, halt_cmd, reg_read, step_go, mem_go;
    logic [CW-1:0] step_val;
    assign req_ok   = dbg_req && id_ok;
    assign halt_cmd = req_ok && (state == ST_HALT) && dbg_mode;
    assign reg_read = req_ok && (op == OP_READ) && !is_mem && (state != ST_RUN);
    assign step_val = dbg_wdata[CW-1:0];
    assign step_go  = halt_cmd && (op == OP_STEP) && (step_val != '0);
    assign mem_go   = halt_cmd && is_mem && ((op == OP_READ) || (op == OP_WRITE));

    // step counter
    logic [CW-1:0] remain;
    logic          last;
    dbg_step_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(!dbg_mode), .load(step_go),
        .load_val(step_val), .dec((state == ST_STEP) && core_rise),
        .remain(remain), .last(last)
    );

    // pending memory access
    logic [MEM_AW-1:0] mem_idx_q;
    logic [DW-1:0]     mem_wd_q;
    logic              mem_wr_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_idx_q <= '0;
            mem_wd_q  <= '0;
            mem_wr_q  <= 1'b0;
        end else if (mem_go) begin
            mem_idx_q <= reg_addr[MEM_AW-1:0];
            mem_wd_q  <= dbg_wdata;
            mem_wr_q  <= (op == OP_WRITE);
        end
    end

    logic          mem_fire;
    logic [DW-1:0] mem_rd;
    assign mem_fire = (state == ST_MEM) && dma_rise && dbg_mode;
    dbg_dma_mem #(.DW(DW), .MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .we(mem_fire && mem_wr_q), .idx(mem_idx_q),
        .wdata(mem_wd_q), .rdata(mem_rd)
    );

    // next state
    always_comb begin
        state_nx = state;
        if (!dbg_mode) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:  state_nx = ST_HALT;
                ST_HALT: begin
                    if (step_go)     state_nx = ST_STEP;
                    else if (mem_go) state_nx = ST_MEM;
                end
                ST_STEP: if (core_rise && last) state_nx = ST_HALT;
                ST_MEM:  if (dma_rise)          state_nx = ST_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // outputs decoded from state
    logic frozen, pending, busy;
    always_comb begin
        core_en = 1'b0;
        frozen  = 1'b0;
        pending = 1'b0;
        busy    = 1'b0;
        unique case (state)
            ST_RUN:  core_en = 1'b1;
            ST_HALT: frozen  = 1'b1;
            ST_STEP: begin core_en = 1'b1; pending = 1'b1; end
            ST_MEM:  begin frozen = 1'b1; busy = 1'b1; end
        endcase
    end

    // register read mux
    logic [DW-1:0] reg_val;
    always_comb begin
        unique case (reg_addr)
            A_STATUS: reg_val = {{(DW-3){1'b0}}, busy, pending, frozen};
            A_REMAIN: reg_val = {{(DW-CW){1'b0}}, remain};
            A_IDENT:  reg_val = {{(DW-CHIP_W-MOD_W){1'b0}}, CHIP_ID, MOD_ID};
            default:  reg_val = '0;
        endcase
    end

    // read-data register
    always_ff @(posedge clk) begin
        if (!rst_n)                     dbg_rdata <= '0;
        else if (dbg_req && !id_ok)     dbg_rdata <= '0;
        else if (mem_fire && !mem_wr_q) dbg_rdata <= mem_rd;
        else if (reg_read)              dbg_rdata <= reg_val;
    end
endmodule

// File: rtl/dbg_slave_chk.sv
module dbg_slave_chk #(
    parameter int CHIP_W = 4,
    parameter int MOD_W  = 4,
    parameter int REG_AW = 6,
    parameter int DW     = 16,
    parameter int CW     = 8,
    parameter logic [CHIP_W-1:0] CHIP_ID = 4'h5,
    parameter logic [MOD_W-1:0]  MOD_ID  = 4'h7,
    localparam int AW = CHIP_W + MOD_W + dbg_pkg::OP_W + REG_AW
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dbg_mode,
    input logic                dbg_req,
    input logic [AW-1:0]       dbg_addr,
    input logic [DW-1:0]       dbg_wdata,
    input logic [DW-1:0]       dbg_rdata,
    input logic                core_en,
    input dbg_pkg::dbg_state_e st,
    input logic                core_rise,
    input logic [CW-1:0]       remain
);
    logic foreign, zero_step;
    assign foreign = dbg_addr[AW-1 -: CHIP_W] != CHIP_ID;
    assign zero_step = dbg_req && !foreign
                    && (dbg_addr[AW-CHIP_W-1 -: MOD_W] == MOD_ID)
                    && (dbg_addr[REG_AW +: 2] == 2'd3)
                    && (dbg_wdata[CW-1:0] == '0);

    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode |=> core_en);

    a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_mode) |=> !core_en);

    a_r4_foreign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && foreign) |=> (dbg_rdata == '0));

    a_r5_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (st == dbg_pkg::ST_STEP && dbg_mode && core_rise) |=> (remain == $past(remain) - CW'(1)));

    a_r5_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == dbg_pkg::ST_STEP) |-> (remain != '0));

    a_r6_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_step && st == dbg_pkg::ST_HALT && dbg_mode) |=> !core_en);
endmodule

bind emu_dbg_slave dbg_slave_chk #(
    .CHIP_W(CHIP_W), .MOD_W(MOD_W), .REG_AW(REG_AW), .DW(DW), .CW(CW),
    .CHIP_ID(CHIP_ID), .MOD_ID(MOD_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .dbg_req(dbg_req),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .core_en(core_en), .st(state), .core_rise(core_rise), .remain(remain)
);

// File: tb/sim_emu_dbg_slave.sv
`timescale 1ns/1ps
module sim_emu_dbg_slave;
    localparam logic [3:0] ID  = 4'h5;
    localparam logic [3:0] MID = 4'h7;

    logic        clk = 1'b0;
    logic        rst_n, dbg_mode, dbg_req, core_clk_in, dma_clk_in;
    logic [15:0] dbg_addr, dbg_wdata, dbg_rdata;
    logic        core_en;

    int checks = 0, errors = 0, en_rises = 0;
    bit done = 0;

    always #10 clk = ~clk;

    emu_dbg_slave u0 (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .dbg_req(dbg_req),
        .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .core_clk_in(core_clk_in),
        .dma_clk_in(dma_clk_in), .dbg_rdata(dbg_rdata), .core_en(core_en)
    );

    // divided core clock: toggles every 4 fabric cycles; counts rises seen with enable high
    initial begin
        int ph;
        ph = 0;
        core_clk_in = 1'b0;
        forever begin
            @(negedge clk);
            ph++;
            if (ph == 4) begin
                ph = 0;
                if (!core_clk_in && core_en === 1'b1) en_rises++;
                core_clk_in = ~core_clk_in;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic cmd(logic [3:0] chip, logic [3:0] md, logic [1:0] op,
                       logic [5:0] a, logic [15:0] wd);
        @(negedge clk);
        dbg_req   = 1'b1;
        dbg_addr  = {chip, md, op, a};
        dbg_wdata = wd;
        @(negedge clk);
        dbg_req   = 1'b0;
    endtask

    task automatic dma_pulse();
        @(negedge clk);
        dma_clk_in = 1'b1;
        @(negedge clk);
        dma_clk_in = 1'b0;
    endtask

    function automatic logic [15:0] pat(int k);
        return 16'(k * 16'h1111) ^ 16'hA5C3;
    endfunction

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
        end
    end

    initial begin
        int b;
        logic [15:0] r;
        rst_n = 1'b0; dbg_mode = 1'b1; dbg_req = 1'b0; dma_clk_in = 1'b0;
        dbg_addr = '0; dbg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 core_en", core_en, 0);
        chk("R1 rdata", dbg_rdata, 0);

        // identity and mismatches
        cmd(ID, MID, 2'd1, 6'd2, 0);     chk("R7 ident", dbg_rdata, 16'h0057);
        cmd(4'h3, MID, 2'd1, 6'd2, 0);   chk("R4 foreign chip", dbg_rdata, 0);
        cmd(ID, MID, 2'd1, 6'd2, 0);     chk("R10 ident again", dbg_rdata, 16'h0057);
        cmd(ID, 4'h2, 2'd1, 6'd2, 0);    chk("R4 foreign module", dbg_rdata, 0);
        cmd(ID, MID, 2'd1, 6'd2, 0);
        cmd(ID, MID, 2'd0, 6'd0, 0);     chk("R3 op none", dbg_rdata, 16'h0057);
        cmd(ID, MID, 2'd1, 6'd0, 0);     chk("R7 status halted", dbg_rdata, 1);

        b = en_rises;
        cmd(4'hA, MID, 2'd3, 0, 5);
        cmd(ID, 4'h1, 2'd3, 0, 5);
        repeat (64) @(negedge clk);
        chk("R4 foreign step edges", en_rises - b, 0);
        chk("R4 foreign step core_en", core_en, 0);

        // step sweep, including zero
        for (int n = 0; n <= 9; n++) begin
            b = en_rises;
            cmd(ID, MID, 2'd3, 0, 16'(n));
            repeat (8 * (n + 3)) @(negedge clk);
            chk(n == 0 ? "R6 zero step edges" : "R5 step edges", en_rises - b, n);
            chk("R5 halted after step", core_en, 0);
            cmd(ID, MID, 2'd1, 6'd0, 0);
            chk("R7 status after step", dbg_rdata, 1);
        end

        // status during a long step; memory access ignored while stepping
        b = en_rises;
        cmd(ID, MID, 2'd3, 0, 37);
        cmd(ID, MID, 2'd1, 6'd0, 0);     chk("R7 status pending", dbg_rdata, 2);
        cmd(ID, MID, 2'd1, 6'd1, 0);
        r = dbg_rdata;
        chk("R7 remain in range", (r >= 1 && r <= 37), 1);
        cmd(ID, MID, 2'd1, 6'd32, 0);    chk("R9 mem ignored in step", dbg_rdata, r);
        repeat (8 * 40) @(negedge clk);
        chk("R5 step 37 edges", en_rises - b, 37);
        cmd(ID, MID, 2'd1, 6'd0, 0);     chk("R9 not busy after step", dbg_rdata, 1);

        // memory writes through DMA edges
        for (int k = 0; k < 16; k++) begin
            cmd(ID, MID, 2'd2, 6'(32 + k), pat(k));
            cmd(ID, MID, 2'd1, 6'd0, 0);  chk("R8 busy on write", dbg_rdata, 5);
            dma_pulse();
            cmd(ID, MID, 2'd1, 6'd0, 0);  chk("R8 write done", dbg_rdata, 1);
        end
        for (int k = 0; k < 16; k++) begin
            cmd(ID, MID, 2'd1, 6'(32 + k), 0);
            dma_pulse();
            chk("R8 readback", dbg_rdata, pat(k));
        end

        // write while busy is ignored
        cmd(ID, MID, 2'd1, 6'd35, 0);
        cmd(ID, MID, 2'd2, 6'd35, 16'hFFFF);
        dma_pulse();                     chk("R9 busy read", dbg_rdata, pat(3));
        cmd(ID, MID, 2'd1, 6'd35, 0);
        dma_pulse();                     chk("R9 busy write dropped", dbg_rdata, pat(3));

        // free run and freeze
        @(negedge clk); dbg_mode = 1'b0;
        @(negedge clk);                  chk("R2 release", core_en, 1);
        cmd(ID, MID, 2'd1, 6'd2, 0);     chk("R9 run ignores read", dbg_rdata, pat(3));
        b = en_rises;
        repeat (80) @(negedge clk);
        chk("R2 run edges", en_rises - b, 10);
        dbg_mode = 1'b1;
        @(negedge clk);                  chk("R2 freeze", core_en, 0);
        b = en_rises;
        repeat (40) @(negedge clk);
        chk("R2 frozen edges", en_rises - b, 0);

        done = 1;
        summary();
    end
endmodule